// File: doc/BRIEF.md
# Framed Word Serializer with Alignment Pattern

This block is the transmit half of a parallel-to-serial link. Everything runs in one bit-clock domain. An internal modulo-20 counter splits the bit clock into word periods and raises a one-cycle word strobe that tells the upstream source when its 18-bit word is taken. Each word gets a leading 1 and a trailing 0 to form a 20-bit frame, and the frame leaves one bit per clock. A remote receiver can then find word boundaries by watching for the fixed 1-to-0 edge between the stop bit and the next start bit.

Three controls act on the stream. A sync request swaps the data for a fixed alignment word (nine ones, then nine zeros), so the receiver can lock at once. A loopback enable drops the external output enable and sends the stream out on an internal loopback pin. A pre-emphasis enable marks each bit that starts a new run of equal bits. A master enable powers the block down when low. When it rises again, the block runs a quiet start-up sequence of 16 word periods before it sends the first frame. The external driver's high-impedance state appears here as a low output-enable bit.

Top module: `frame_serializer`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `ser_out`, `ser_oe`, `loop_out`, `emph_flag` and `word_strobe` are all 0.
- R2: A word is sampled at the rising edge that ends a cycle with `word_strobe` high. In the next 20 cycles the stream carries bit 1 first, then the word from bit 17 down to bit 0, then bit 0.
- R3: During transmission `word_strobe` is high for exactly one cycle in every 20.
- R4: If `sync_req` is high at the sampling edge, the 18-bit payload is 18'h3FE00: bits 17..9 are 1 and bits 8..0 are 0. The whole frame is then 20'hFFC00.
- R5: `ser_oe` is 1 only for a transmitted bit whose edge saw `loop_en` low. It is 0 in power-down, during start-up and in loopback.
- R6: When `loop_en` is high at an edge, `ser_out` is 0 and the bit appears on `loop_out`. Otherwise `loop_out` is 0.
- R7: When `preemph_en` is high at an edge, `emph_flag` is 1 for a bit that differs from the previous stream bit. The first bit after start-up is compared with 0, so a single-bit run is always marked. When `preemph_en` is low, `emph_flag` is 0.
- R8: An edge that sees `enable` low puts the block in power-down. From the next cycle all outputs are 0, even in the middle of a frame.
- R9: After an edge that sees `enable` high in power-down, all outputs stay 0 for 320 cycles (16 word periods). `word_strobe` first rises after the 321st such edge, counting that first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Low: power-down; rising: start-up then transmit |
| word_in | input | 18 | Parallel data word, sampled after a strobe cycle |
| sync_req | input | 1 | Replace the word with the alignment pattern |
| loop_en | input | 1 | Route the stream to `loop_out`, disable the external output |
| preemph_en | input | 1 | Enable run-start marking on `emph_flag` |
| word_strobe | output | 1 | High in the cycle before the word is sampled |
| ser_out | output | 1 | External serial data |
| ser_oe | output | 1 | External output enable (low models high impedance) |
| loop_out | output | 1 | Internal loopback serial data |
| emph_flag | output | 1 | Marks a bit that needs extra drive swing |

## Verification
- **Bit counter out of step.** A slipped bit counter moves the strobe away from the stop bit. This shows within one word period: a frame of the wrong length, or a start bit that is not 1.
- **Wrong shift-register contents.** A corrupt shift register shows directly as a bad data bit in the cycle that bit is sent.
- **Stale run-tracking bit.** If the stored previous bit is stale after start-up or a power-down, the first bit's emphasis mark is wrong.
- **Broken start-up counter.** A start-up counter that ends early or late moves the first strobe away from exactly 321 cycles after enable.

The bench compares every port against a behavioural model on every clock, so each of these faults is seen in the cycle it reaches a port.

// File: rtl/frame_ser_pkg.sv
package frame_ser_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2
  } tx_state_e;

  localparam logic LEAD_BIT  = 1'b1;
  localparam logic TRAIL_BIT = 1'b0;

endpackage

// File: rtl/frame_assembler.sv
module frame_assembler #(
  parameter int DATA_W = 18
) (
  input  logic [DATA_W-1:0] word,
  input  logic              sync,
  output logic [DATA_W+1:0] frame
);
  import frame_ser_pkg::*;

  localparam int ONES_W = DATA_W - DATA_W / 2;

  logic [DATA_W-1:0] align_word;
  logic [DATA_W-1:0] payload;

  // Alignment word: upper half ones, lower half zeros.
  for (genvar i = 0; i < DATA_W; i++) begin : g_align
    assign align_word[i] = (i >= DATA_W - ONES_W);
  end

  assign payload = sync ? align_word : word;
  assign frame   = {LEAD_BIT, payload, TRAIL_BIT};

endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int FRAME_W    = 20,
  parameter int INIT_WORDS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  output logic tx_active,
  output logic load,
  output logic strobe_q
);
  import frame_ser_pkg::*;

  localparam int INIT_LEN = INIT_WORDS * FRAME_W;
  localparam int CW       = $clog2(FRAME_W);
  localparam int IW       = $clog2(INIT_LEN);
  localparam logic [CW-1:0] CNT_LAST  = CW'(FRAME_W - 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_LEN - 1);

  tx_state_e     state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [IW-1:0] icnt_q, icnt_n;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    icnt_n  = icnt_q;
    if (!enable) begin
      state_n = ST_OFF;
      cnt_n   = '0;
      icnt_n  = '0;
    end else begin
      case (state_q)
        ST_OFF: begin
          state_n = ST_INIT;
          icnt_n  = '0;
        end
        ST_INIT: begin
          if (icnt_q == INIT_LAST) begin
            state_n = ST_RUN;
            cnt_n   = '0;
          end else begin
            icnt_n = icnt_q + 1'b1;
          end
        end
        ST_RUN: cnt_n = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        default: state_n = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OFF;
      cnt_q    <= '0;
      icnt_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      cnt_q    <= cnt_n;
      icnt_q   <= icnt_n;
      strobe_q <= (state_n == ST_RUN) && (cnt_n == '0);
    end
  end

  assign tx_active = (state_q == ST_RUN) && enable;
  assign load      = tx_active && (cnt_q == '0);

  assert_strobe_gap_R3: assert property (@(posedge clk) disable iff (rst)
    strobe_q |=> !strobe_q);

  assert_powerdown_R8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (state_q == ST_OFF) && !strobe_q);

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  output logic               bit_now
);

  logic [FRAME_W-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
    end else if (load) begin
      shreg_q <= {frame[FRAME_W-2:0], 1'b0};
    end else begin
      shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign bit_now = load ? frame[FRAME_W-1] : shreg_q[FRAME_W-1];

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
  parameter int DATA_W     = 18,
  parameter int INIT_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DATA_W-1:0] word_in,
  input  logic              sync_req,
  input  logic              loop_en,
  input  logic              preemph_en,
  output logic              word_strobe,
  output logic              ser_out,
  output logic              ser_oe,
  output logic              loop_out,
  output logic              emph_flag
);

  localparam int FRAME_W = DATA_W + 2;

  logic [FRAME_W-1:0] frame;
  logic tx_active, load, bit_now, prev_q;

  frame_assembler #(.DATA_W(DATA_W)) asm_i (
    .word (word_in),
    .sync (sync_req),
    .frame(frame)
  );

  frame_seq #(.FRAME_W(FRAME_W), .INIT_WORDS(INIT_WORDS)) seq_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .tx_active(tx_active),
    .load     (load),
    .strobe_q (word_strobe)
  );

  frame_shifter #(.FRAME_W(FRAME_W)) shf_i (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .frame  (frame),
    .bit_now(bit_now)
  );

  always_ff @(posedge clk) begin
    if (rst || !tx_active) begin
      ser_out   <= 1'b0;
      ser_oe    <= 1'b0;
      loop_out  <= 1'b0;
      emph_flag <= 1'b0;
      prev_q    <= 1'b0;
    end else begin
      ser_out   <= loop_en ? 1'b0 : bit_now;
      loop_out  <= loop_en ? bit_now : 1'b0;
      ser_oe    <= !loop_en;
      emph_flag <= preemph_en && (bit_now != prev_q);
      prev_q    <= bit_now;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !ser_oe && !word_strobe && !ser_out && !loop_out && !emph_flag);

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (word_strobe && enable && !loop_en) |=> ser_out);

  assert_oe_loop_R5: assert property (@(posedge clk) disable iff (rst)
    ser_oe |-> !loop_out);

  assert_loop_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> !ser_out && !ser_oe);

  assert_emph_off_R7: assert property (@(posedge clk) disable iff (rst)
    !preemph_en |=> !emph_flag);

endmodule

// File: tb/frame_serializer_tb_top.sv
module frame_serializer_tb_top;

  localparam int DW       = 18;
  localparam int FW       = 20;
  localparam int INIT_LEN = 16 * FW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [DW-1:0] word_in = '0;
  logic sync_req = 1'b0, loop_en = 1'b0, preemph_en = 1'b0;
  logic word_strobe, ser_out, ser_oe, loop_out, emph_flag;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  frame_serializer dut_i (
    .clk(clk), .rst(rst), .enable(enable), .word_in(word_in),
    .sync_req(sync_req), .loop_en(loop_en), .preemph_en(preemph_en),
    .word_strobe(word_strobe), .ser_out(ser_out), .ser_oe(ser_oe),
    .loop_out(loop_out), .emph_flag(emph_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int  ms = 0, ic = 0, bc = 0;
  bit  prev = 0, mvalid = 0;
  bit  e_ser = 0, e_oe = 0, e_lp = 0, e_em = 0, e_stb = 0;
  bit  bq[$];

  task automatic quiet();
    e_ser = 0; e_oe = 0; e_lp = 0; e_em = 0; e_stb = 0; prev = 0;
  endtask

  always @(posedge clk) begin
    bit b;
    if (rst) begin
      ms = 0; quiet(); bq.delete();
    end else if (!enable) begin
      ms = 0; quiet(); bq.delete();
    end else begin
      case (ms)
        0: begin ms = 1; ic = 0; quiet(); end
        1: begin
          quiet();
          if (ic == INIT_LEN - 1) begin ms = 2; bc = 0; e_stb = 1; end
          else ic++;
        end
        default: begin
          if (bc == 0) begin
            bq.delete();
            bq.push_back(1'b1);
            for (int i = DW - 1; i >= 0; i--)
              bq.push_back(sync_req ? (i >= DW / 2) : word_in[i]);
            bq.push_back(1'b0);
          end
          b     = bq.pop_front();
          e_ser = loop_en ? 1'b0 : b;
          e_lp  = loop_en ? b : 1'b0;
          e_oe  = !loop_en;
          e_em  = preemph_en && (b != prev);
          prev  = b;
          bc    = (bc + 1) % FW;
          e_stb = (bc == 0);
        end
      endcase
    end
    mvalid = 1;
  end

  always @(negedge clk) begin
    if (mvalid && !done) begin
      chk(ser_out == e_ser, "R2", "ser_out", ser_out, e_ser);
      chk(ser_oe == e_oe, "R5", "ser_oe", ser_oe, e_oe);
      chk(loop_out == e_lp, "R6", "loop_out", loop_out, e_lp);
      chk(emph_flag == e_em, "R7", "emph_flag", emph_flag, e_em);
      chk(word_strobe == e_stb, "R3", "word_strobe", word_strobe, e_stb);
    end
  end

  // Wait for a strobe, drive one word and its controls, capture 20 bits.
  task automatic send(input logic [DW-1:0] w, input bit s, input bit lp,
                      input bit em, output logic [FW-1:0] cap);
    while (!word_strobe) @(negedge clk);
    word_in = w; sync_req = s; loop_en = lp; preemph_en = em;
    cap = '0;
    for (int k = 0; k < FW; k++) begin
      @(negedge clk);
      cap = {cap[FW-2:0], (lp ? loop_out : ser_out)};
    end
  endtask

  task automatic wait_first_strobe(input string req);
    int n = 0;
    enable = 1'b1;
    do begin
      @(negedge clk);
      n++;
      if (!word_strobe) chk(!ser_oe && !ser_out, req, "quiet start-up", ser_oe, 0);
    end while (!word_strobe && n < 2000);
    chk(n == INIT_LEN + 1, req, "cycles to first strobe", n, INIT_LEN + 1);
  endtask

  initial begin
    logic [FW-1:0] cap;
    logic [DW-1:0] lfsr = 18'h1B3C5;
    repeat (4) @(negedge clk);
    chk({ser_out, ser_oe, loop_out, emph_flag, word_strobe} == 5'b0,
        "R1", "outputs in reset", {ser_out, ser_oe, loop_out, emph_flag, word_strobe}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({ser_out, ser_oe, word_strobe} == 3'b0, "R1", "after reset", ser_oe, 0);

    wait_first_strobe("R9");

    send(18'h3FFFF, 0, 0, 0, cap);
    chk(cap == 20'hFFFFE, "R2", "frame all ones", cap, 20'hFFFFE);
    send(18'h00000, 0, 0, 1, cap);
    chk(cap == 20'h80000, "R2", "frame all zeros", cap, 20'h80000);
    send(18'h2AAAA, 0, 0, 1, cap);
    chk(cap == {1'b1, 18'h2AAAA, 1'b0}, "R2", "alternating", cap, {1'b1, 18'h2AAAA, 1'b0});
    send(18'h12345, 1, 0, 1, cap);
    chk(cap == 20'hFFC00, "R4", "sync frame", cap, 20'hFFC00);
    send(18'h2D5A3, 0, 1, 1, cap);
    chk(cap == {1'b1, 18'h2D5A3, 1'b0}, "R6", "loopback frame", cap, {1'b1, 18'h2D5A3, 1'b0});
    send(18'h0F0F0, 1, 1, 0, cap);
    chk(cap == 20'hFFC00, "R4", "sync over loopback", cap, 20'hFFC00);
    for (int j = 0; j < 12; j++) begin
      lfsr = {lfsr[DW-2:0], lfsr[17] ^ lfsr[10]};
      send(lfsr, 0, (j % 5) == 3, j[0], cap);
      chk(cap == {1'b1, lfsr, 1'b0}, "R2", "lfsr frame", cap, {1'b1, lfsr, 1'b0});
    end

    // Power-down in the middle of a frame
    while (!word_strobe) @(negedge clk);
    word_in = 18'h3C3C3; sync_req = 0; loop_en = 0; preemph_en = 1;
    repeat (7) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk({ser_out, ser_oe, loop_out, emph_flag, word_strobe} == 5'b0, "R8",
        "power-down outputs", {ser_out, ser_oe, loop_out, emph_flag, word_strobe}, 0);
    repeat (5) @(negedge clk);
    chk(!ser_oe && !word_strobe, "R8", "stays down", ser_oe, 0);
    wait_first_strobe("R9");
    send(18'h00001, 0, 0, 1, cap);
    chk(cap == {1'b1, 18'h00001, 1'b0}, "R2", "frame after restart", cap, {1'b1, 18'h00001, 1'b0});
    send(18'h15555, 0, 0, 1, cap);
    chk(cap == {1'b1, 18'h15555, 1'b0}, "R2", "frame 15555", cap, {1'b1, 18'h15555, 1'b0});

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule